// File: doc/BRIEF.md
# Linked-Descriptor Scatter DMA Engine

This engine moves data between system memory and a peripheral data port by walking a chain of descriptor records kept in memory. Software sets a descriptor pointer and a direction, then sets the run bit. The engine fetches a record and moves the requested number of bytes, one 32-bit word at a time, to or from that record's buffer. It then follows the record's branch address to the next record. It stops after a record that carries the last-record flag. When the chain ends, or when an error occurs, the engine stores a 4-bit event code, clears run, and sets an interrupt pending flag.

Each descriptor is a 16-byte record. Word 0 holds the flags, word 1 the buffer address and word 2 the branch address. Word 3 is reserved. In the flags word, bits 15:0 give the byte count, bit 30 is a format marker that must be one, and bit 31 marks the last record. The memory side uses a request/ready word port. A request keeps its address, write enable and write data until a cycle in which ready is high; read data and the error flag are valid in that same cycle. Each peripheral side is a valid/ready stream. A transfer happens on a rising edge where both valid and ready are high. The outbound stream holds valid and data until ready. The inbound stream may drop valid at any time and is never forced to hold. The inbound stream also has an end-of-data marker that travels with each word.

Top module: `chain_dma`

## Requirements
- R1: After reset every control register reads zero, the interrupt output is low and no memory request is made.
- R2: Control register 0: bit 0 is the engine enable and reads back as written. Writing one to bit 8 aborts any transfer in progress and clears run, direction, event and pending. Bit 8 always reads zero. After such an abort the engine accepts a new start.
- R3: A descriptor is fetched as three word reads, in order, at pointer, pointer+4 and pointer+8. These give the flags, the buffer address and the branch address. The fourth word of the record is never read.
- R4: With direction 0, the engine reads ceil(count/4) words from the buffer at ascending word addresses. It sends them on the outbound stream in the same order.
- R5: With direction 1, the engine takes ceil(count/4) words from the inbound stream. It writes them to the buffer at ascending word addresses, in arrival order, and accepts no extra word.
- R6: After a record without the last flag, the next record is fetched from its branch address. A record with byte count zero moves no data.
- R7: When the record with the last flag finishes, the event field becomes 15, run clears and the pending flag sets.
- R8: A memory error while fetching a descriptor stops the engine with event 3. A flags word with bit 30 clear does the same. No data of that record moves.
- R9: A memory error on a buffer read or write stops the engine with event 4. No further word moves.
- R10: In direction 1, an end-of-data marker on a word stops the engine with event 5 unless that word is the final word of the last-flagged record. In that case the result is event 15.
- R11: The interrupt output equals pending AND bit 0 of register 1. Register 2 bit 0 shows pending, and writing one to it clears pending.
- R12: Register 4 holds the event in bits 3:0, run in bit 7 and direction in bit 22. Writing it while the engine is idle loads all three fields, so writing zero clears them. Writes to it while the engine is busy are ignored. A transfer starts only while both run and enable are set. Register 3 holds the descriptor pointer.
- R13: A memory request holds its address and write enable until ready. Outbound valid holds its data until ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register index (0 control, 1 interrupt enable, 2 pending, 3 pointer, 4 channel) |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Memory read data |
| mem_err | input | 1 | Memory access failed (with ready) |
| tx_valid | output | 1 | Outbound word valid |
| tx_data | output | 32 | Outbound word |
| tx_ready | input | 1 | Peripheral accepts outbound word |
| rx_valid | input | 1 | Inbound word valid |
| rx_data | input | 32 | Inbound word |
| rx_last | input | 1 | Inbound word is the peripheral's last |
| rx_ready | output | 1 | Engine accepts inbound word |

## Verification
A wrong sequencer state or a wrong word counter shows up at the ports within one descriptor. Either a word goes to the wrong address or out of order on a stream, or one word too many or too few moves. When the chain stops, the event field in register 4 also reads differently. A broken branch or a broken last-flag decision shows as a memory read at an address outside the built chain, or as a missing pending flag once the transfer should have ended. The sweeps vary chain length, words per record, memory latency and stream back-pressure, so a counter that is off by one is exposed in the first affected record.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam int WORD_W = 32;
  localparam int CSR_AW = 3;

  localparam logic [CSR_AW-1:0] REG_GCTL  = 3'd0;
  localparam logic [CSR_AW-1:0] REG_IEN   = 3'd1;
  localparam logic [CSR_AW-1:0] REG_ISTAT = 3'd2;
  localparam logic [CSR_AW-1:0] REG_DPTR  = 3'd3;
  localparam logic [CSR_AW-1:0] REG_CHAN  = 3'd4;

  localparam int GCTL_EN_BIT   = 0;
  localparam int GCTL_SRST_BIT = 8;
  localparam int CHAN_RUN_BIT  = 7;
  localparam int CHAN_DIR_BIT  = 22;
  localparam int FLAG_FMT_BIT  = 30;
  localparam int FLAG_END_BIT  = 31;

  typedef enum logic [3:0] {
    EV_NONE      = 4'd0,
    EV_UNDERRUN  = 4'd1,
    EV_OVERRUN   = 4'd2,
    EV_DESC_ERR  = 4'd3,
    EV_DATA_ERR  = 4'd4,
    EV_EARLY_END = 4'd5,
    EV_OK        = 4'd15
  } dma_event_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC,
    ST_RD,
    ST_TX,
    ST_RX,
    ST_WR
  } dma_state_e;
endpackage

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [3:0]        done_ev_i,
  output logic              go_o,
  output logic              dir_o,
  output logic              clr_o,
  output logic              irq_o,
  output logic [ADDR_W-1:0] desc_ptr_o
);
  logic              en_q, ie_q, pend_q, run_q, dir_q;
  logic [3:0]        ev_q;
  logic [ADDR_W-1:0] ptr_q;

  logic wr_gctl, wr_ien, wr_stat, wr_ptr, wr_chan, clr_w;
  assign wr_gctl = csr_we && (csr_addr == REG_GCTL);
  assign wr_ien  = csr_we && (csr_addr == REG_IEN);
  assign wr_stat = csr_we && (csr_addr == REG_ISTAT);
  assign wr_ptr  = csr_we && (csr_addr == REG_DPTR);
  assign wr_chan = csr_we && (csr_addr == REG_CHAN);
  assign clr_w   = wr_gctl && csr_wdata[GCTL_SRST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
      dir_q  <= 1'b0;
      ev_q   <= EV_NONE;
      ptr_q  <= '0;
    end else begin
      if (wr_gctl) en_q <= csr_wdata[GCTL_EN_BIT];
      if (wr_ien)  ie_q <= csr_wdata[0];
      if (wr_ptr)  ptr_q <= csr_wdata[ADDR_W-1:0];
      if (clr_w) begin
        run_q  <= 1'b0;
        dir_q  <= 1'b0;
        ev_q   <= EV_NONE;
        pend_q <= 1'b0;
      end else begin
        if (done_i) begin
          run_q  <= 1'b0;
          ev_q   <= done_ev_i;
          pend_q <= 1'b1;
        end else begin
          if (wr_chan && !busy_i) begin
            run_q <= csr_wdata[CHAN_RUN_BIT];
            dir_q <= csr_wdata[CHAN_DIR_BIT];
            ev_q  <= csr_wdata[3:0];
          end
          if (wr_stat && csr_wdata[0]) pend_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      REG_GCTL:  csr_rdata[GCTL_EN_BIT] = en_q;
      REG_IEN:   csr_rdata[0] = ie_q;
      REG_ISTAT: csr_rdata[0] = pend_q;
      REG_DPTR:  csr_rdata = WORD_W'(ptr_q);
      REG_CHAN: begin
        csr_rdata[3:0]          = ev_q;
        csr_rdata[CHAN_RUN_BIT] = run_q;
        csr_rdata[CHAN_DIR_BIT] = dir_q;
      end
      default:   csr_rdata = '0;
    endcase
  end

  assign go_o       = run_q && en_q;
  assign dir_o      = dir_q;
  assign clr_o      = clr_w;
  assign irq_o      = pend_q && ie_q;
  assign desc_ptr_o = ptr_q;

  // R7
  done_effect_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_w)
    done_i |=> (!run_q && pend_q));

  // R11
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_w)
    (wr_stat && csr_wdata[0] && !done_i) |=> !pend_q);

  // R12
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_w)
    (wr_chan && busy_i && !done_i) |=> ($stable(dir_q) && $stable(run_q)));
endmodule

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              go_i,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] desc_ptr_i,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              tx_valid,
  output logic [WORD_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_last,
  output logic              rx_ready,
  output logic              busy_o,
  output logic              done_o,
  output logic [3:0]        done_ev_o
);
  localparam int WC_W = CNT_W - 1;

  dma_state_e        state_q;
  logic [ADDR_W-1:0] cur_ptr_q, buf_q, branch_q;
  logic [WC_W-1:0]   words_q;
  logic [1:0]        widx_q;
  logic              end_q, dir_q, last_q, done_q;
  logic [3:0]        ev_q;
  logic [WORD_W-1:0] data_q;

  logic [CNT_W:0]    cnt_ext;
  logic [WC_W-1:0]   words_new;
  logic              final_word;
  assign cnt_ext    = {1'b0, mem_rdata[CNT_W-1:0]} + (CNT_W+1)'(3);
  assign words_new  = cnt_ext[CNT_W:2];
  assign final_word = (words_q == WC_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_ptr_q <= '0;
      buf_q     <= '0;
      branch_q  <= '0;
      words_q   <= '0;
      widx_q    <= '0;
      end_q     <= 1'b0;
      dir_q     <= 1'b0;
      last_q    <= 1'b0;
      done_q    <= 1'b0;
      ev_q      <= EV_NONE;
      data_q    <= '0;
    end else if (clr_i) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (go_i && !done_q) begin
            cur_ptr_q <= desc_ptr_i;
            dir_q     <= dir_i;
            widx_q    <= '0;
            state_q   <= ST_DESC;
          end
        end
        ST_DESC: begin
          if (mem_ready) begin
            if (mem_err) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              ev_q    <= EV_DESC_ERR;
            end else begin
              case (widx_q)
                2'd0: begin
                  if (!mem_rdata[FLAG_FMT_BIT]) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    ev_q    <= EV_DESC_ERR;
                  end else begin
                    words_q <= words_new;
                    end_q   <= mem_rdata[FLAG_END_BIT];
                    widx_q  <= 2'd1;
                  end
                end
                2'd1: begin
                  buf_q  <= mem_rdata[ADDR_W-1:0];
                  widx_q <= 2'd2;
                end
                default: begin
                  branch_q <= mem_rdata[ADDR_W-1:0];
                  widx_q   <= '0;
                  if (words_q != '0) begin
                    state_q <= dir_q ? ST_RX : ST_RD;
                  end else if (end_q) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    ev_q    <= EV_OK;
                  end else begin
                    cur_ptr_q <= mem_rdata[ADDR_W-1:0];
                  end
                end
              endcase
            end
          end
        end
        ST_RD: begin
          if (mem_ready) begin
            if (mem_err) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              ev_q    <= EV_DATA_ERR;
            end else begin
              data_q  <= mem_rdata;
              state_q <= ST_TX;
            end
          end
        end
        ST_TX: begin
          if (tx_ready) begin
            buf_q   <= buf_q + ADDR_W'(4);
            words_q <= words_q - WC_W'(1);
            if (!final_word) begin
              state_q <= ST_RD;
            end else if (end_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              ev_q    <= EV_OK;
            end else begin
              cur_ptr_q <= branch_q;
              state_q   <= ST_DESC;
            end
          end
        end
        ST_RX: begin
          if (rx_valid) begin
            data_q  <= rx_data;
            last_q  <= rx_last;
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (mem_ready) begin
            if (mem_err) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              ev_q    <= EV_DATA_ERR;
            end else if (last_q && !(final_word && end_q)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              ev_q    <= EV_EARLY_END;
            end else begin
              buf_q   <= buf_q + ADDR_W'(4);
              words_q <= words_q - WC_W'(1);
              if (!final_word) begin
                state_q <= ST_RX;
              end else if (end_q) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                ev_q    <= EV_OK;
              end else begin
                cur_ptr_q <= branch_q;
                state_q   <= ST_DESC;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = buf_q;
    case (state_q)
      ST_DESC: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr_q + ADDR_W'({widx_q, 2'b00});
      end
      ST_RD: mem_req = 1'b1;
      ST_WR: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: mem_req = 1'b0;
    endcase
  end

  assign mem_wdata = data_q;
  assign tx_valid  = (state_q == ST_TX);
  assign tx_data   = data_q;
  assign rx_ready  = (state_q == ST_RX);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign done_ev_o = ev_q;

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R13
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    done_q |=> (!done_q && !busy_o));
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              tx_valid,
  output logic [WORD_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_last,
  output logic              rx_ready
);
  logic              busy, done, go, dir, clr;
  logic [3:0]        done_ev;
  logic [ADDR_W-1:0] desc_ptr;

  chain_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_we     (csr_we),
    .csr_addr   (csr_addr),
    .csr_wdata  (csr_wdata),
    .csr_rdata  (csr_rdata),
    .busy_i     (busy),
    .done_i     (done),
    .done_ev_i  (done_ev),
    .go_o       (go),
    .dir_o      (dir),
    .clr_o      (clr),
    .irq_o      (irq),
    .desc_ptr_o (desc_ptr)
  );

  chain_dma_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .go_i       (go),
    .dir_i      (dir),
    .desc_ptr_i (desc_ptr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .mem_err    (mem_err),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_last    (rx_last),
    .rx_ready   (rx_ready),
    .busy_o     (busy),
    .done_o     (done),
    .done_ev_o  (done_ev)
  );

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(done) || $past(csr_we)));
endmodule

// File: tb/chain_dma_test.sv
module chain_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_err = 1'b0;
  logic        tx_valid;
  logic [31:0] tx_data;
  logic        tx_ready = 1'b0;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_data = '0;
  logic        rx_last = 1'b0;
  logic        rx_ready;

  always #4 clk = ~clk;

  chain_dma uut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_ready(rx_ready)
  );

  logic [31:0] mem [0:255];
  logic [31:0] txlog [0:63];
  int tests = 0, fails = 0, cyc = 0;
  int txn = 0, memhs = 0, lat_cnt = 0, lat_sel = 0;
  int rx_i = 0, rx_n = 0, rx_last_at = -1;
  bit tx_bp = 0, rx_gap = 0, rx_en = 0, err_on = 0, rsv_rd = 0;
  logic [31:0] err_addr = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic service();
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        tests++; fails++;
        $display("FAIL R7 watchdog: actual %0d expected below %0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
      if (mem_req) begin
        if (lat_cnt >= lat_sel) begin
          mem_ready = 1'b1;
          mem_err   = err_on && (mem_addr == err_addr);
          mem_rdata = mem[mem_addr[9:2]];
          if (!mem_err && mem_we) mem[mem_addr[9:2]] = mem_wdata;
          if (!mem_we && mem_addr < 32'h200 && mem_addr[3:2] == 2'd3) rsv_rd = 1;
          memhs++;
          lat_cnt = 0;
        end else begin
          mem_ready = 1'b0;
          mem_err   = 1'b0;
          lat_cnt++;
        end
      end else begin
        mem_ready = 1'b0;
        mem_err   = 1'b0;
        lat_cnt   = 0;
      end
      tx_ready = tx_bp ? cyc[0] : 1'b1;
      if (tx_valid && tx_ready && txn < 64) begin
        txlog[txn] = tx_data;
        txn++;
      end
      rx_valid = rx_en && (rx_i < rx_n) && (rx_gap ? cyc[1] : 1'b1);
      rx_data  = 32'h5000_0000 | 32'(rx_i);
      rx_last  = (rx_i == rx_last_at);
      if (rx_valid && rx_ready) rx_i++;
    end
  endtask

  task automatic csr_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    csr_addr = a;
    #1 v = csr_rdata;
  endtask

  task automatic wait_done(output logic [31:0] ch);
    int n = 0;
    do begin
      csr_rd(3'd4, ch);
      n++;
    end while (ch[7] && n < 4000);
    if (n >= 4000) chk(1'b0, "R7 completion", ch, 32'h0);
  endtask

  task automatic put_desc(input int k, input logic [31:0] flags, input logic [31:0] bufa, input logic [31:0] br);
    mem[k*4]   = flags;
    mem[k*4+1] = bufa;
    mem[k*4+2] = br;
    mem[k*4+3] = 32'hDEAD_0000 | 32'(k);
  endtask

  task automatic build_chain(input int nd, input int nw, input int sub);
    for (int k = 0; k < nd; k++) begin
      logic [31:0] f;
      f = 32'h4000_0000 | 32'(nw * 4 - sub);
      if (k == nd - 1) f = f | 32'h8000_0000;
      put_desc(k, f, 32'h200 + 32'(k * 32), 32'((k + 1) * 16));
    end
  endtask

  task automatic fill_bufs(input int nd, input int nw);
    for (int k = 0; k < nd; k++)
      for (int i = 0; i < 8; i++)
        mem[128 + k*8 + i] = (i < nw) ? (32'hC000_0000 | 32'(nd << 16) | 32'(nw << 12) | 32'(k << 8) | 32'(i)) : 32'h0;
  endtask

  task automatic start(input bit dir);
    txn = 0; rx_i = 0; rsv_rd = 0;
    csr_wr(3'd2, 32'h1);
    csr_wr(3'd3, 32'h0);
    csr_wr(3'd4, 32'h0);
    csr_wr(3'd4, (dir ? 32'h0040_0000 : 32'h0) | 32'h80);
  endtask

  logic [31:0] v, ch;
  int okc;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    fork service(); join_none
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    okc = 1;
    for (int r = 0; r < 5; r++) begin
      csr_rd(3'(r), v);
      if (v != 0) okc = 0;
    end
    chk(okc == 1, "R1 registers zero", 32'(okc), 32'h1);
    chk(irq == 0 && mem_req == 0, "R1 irq and request low", {30'b0, irq, mem_req}, 32'h0);

    // R2 enable read back
    csr_wr(3'd0, 32'h1);
    csr_rd(3'd0, v);
    chk(v == 32'h1, "R2 enable readback", v, 32'h1);
    csr_wr(3'd3, 32'h40);
    csr_rd(3'd3, v);
    chk(v == 32'h40, "R12 pointer register", v, 32'h40);

    // R4 R3 R6 R13 sweep: memory to stream
    for (int nd = 1; nd <= 3; nd++) begin
      for (int nw = 1; nw <= 3; nw++) begin
        lat_sel = (nd + nw) % 3;
        tx_bp   = ((nd + nw) % 2) == 1;
        build_chain(nd, nw, (nd + nw) % 4);
        fill_bufs(nd, nw);
        start(1'b0);
        wait_done(ch);
        chk(ch[3:0] == 4'hF, "R7 success event", ch, 32'hF);
        csr_rd(3'd2, v);
        chk(v == 32'h1, "R7 pending set", v, 32'h1);
        chk(txn == nd * nw, "R4 word count", 32'(txn), 32'(nd * nw));
        okc = 1;
        for (int k = 0; k < nd; k++)
          for (int i = 0; i < nw; i++)
            if (txlog[k*nw + i] != (32'hC000_0000 | 32'(nd << 16) | 32'(nw << 12) | 32'(k << 8) | 32'(i))) okc = 0;
        chk(okc == 1, "R4 R6 R13 stream order", 32'(okc), 32'h1);
        chk(rsv_rd == 0, "R3 reserved word untouched", 32'(rsv_rd), 32'h0);
      end
    end
    lat_sel = 0; tx_bp = 0;

    // R5 sweep: stream to memory
    rx_en = 1;
    for (int nd = 1; nd <= 2; nd++) begin
      for (int nw = 1; nw <= 3; nw++) begin
        rx_gap = ((nd + nw) % 2) == 0;
        lat_sel = nw - 1;
        build_chain(nd, nw, nw % 4);
        for (int i = 128; i < 160; i++) mem[i] = '0;
        rx_n = 8; rx_last_at = -1;
        start(1'b1);
        wait_done(ch);
        chk(ch[3:0] == 4'hF && ch[22] == 1'b1, "R5 success and direction", ch, 32'h0040_000F);
        okc = 1;
        for (int k = 0; k < nd; k++)
          for (int i = 0; i < 8; i++)
            if (mem[128 + k*8 + i] != ((i < nw) ? (32'h5000_0000 | 32'(k*nw + i)) : 32'h0)) okc = 0;
        chk(okc == 1, "R5 buffer contents", 32'(okc), 32'h1);
        chk(rx_i == nd * nw, "R5 no extra word", 32'(rx_i), 32'(nd * nw));
      end
    end
    rx_gap = 0; lat_sel = 0;

    // R10 early end marker
    build_chain(2, 2, 0);
    for (int i = 128; i < 160; i++) mem[i] = '0;
    rx_n = 8; rx_last_at = 1;
    start(1'b1);
    wait_done(ch);
    chk(ch[3:0] == 4'h5, "R10 early end event", ch, 32'h5);
    chk(mem[129] == 32'h5000_0001 && mem[136] == 32'h0, "R10 stops after marked word", mem[136], 32'h0);
    rx_last_at = 3;
    start(1'b1);
    wait_done(ch);
    chk(ch[3:0] == 4'hF, "R10 marker on final word", ch, 32'hF);
    chk(rx_i == 4, "R10 words taken", 32'(rx_i), 32'h4);
    rx_last_at = -1; rx_en = 0;

    // R8 format bit clear
    build_chain(1, 2, 0);
    mem[0] = 32'h8000_0008;
    fill_bufs(1, 2);
    start(1'b0);
    wait_done(ch);
    chk(ch[3:0] == 4'h3, "R8 format error event", ch, 32'h3);
    chk(txn == 0, "R8 no data moved", 32'(txn), 32'h0);

    // R8 fetch error on second descriptor
    build_chain(2, 2, 0);
    fill_bufs(2, 2);
    err_on = 1; err_addr = 32'h10;
    start(1'b0);
    wait_done(ch);
    chk(ch[3:0] == 4'h3, "R8 fetch error event", ch, 32'h3);
    chk(txn == 2, "R8 first record delivered", 32'(txn), 32'h2);

    // R9 data read error
    build_chain(1, 3, 0);
    fill_bufs(1, 3);
    err_addr = 32'h204;
    start(1'b0);
    wait_done(ch);
    chk(ch[3:0] == 4'h4, "R9 data error event", ch, 32'h4);
    chk(txn == 1, "R9 stops at failing word", 32'(txn), 32'h1);
    err_on = 0;

    // R6 zero-count record in the middle
    fill_bufs(3, 2);
    put_desc(0, 32'h4000_0008, 32'h200, 32'h10);
    put_desc(1, 32'h4000_0000, 32'h220, 32'h20);
    put_desc(2, 32'hC000_0004, 32'h240, 32'h30);
    start(1'b0);
    wait_done(ch);
    chk(ch[3:0] == 4'hF && txn == 3, "R6 zero count moves nothing", 32'(txn), 32'h3);
    chk(txlog[2] == (32'hC000_0000 | 32'(3 << 16) | 32'(2 << 12) | 32'(2 << 8)), "R6 third record data",
        txlog[2], 32'hC003_2200);

    // R11 interrupt gating and clear
    chk(irq == 0, "R11 masked irq", {31'b0, irq}, 32'h0);
    csr_wr(3'd1, 32'h1);
    #1 chk(irq == 1, "R11 irq after enable", {31'b0, irq}, 32'h1);
    csr_wr(3'd2, 32'h1);
    #1 chk(irq == 0, "R11 write one clears", {31'b0, irq}, 32'h0);
    csr_rd(3'd2, v);
    chk(v == 0, "R11 pending cleared", v, 32'h0);
    csr_wr(3'd1, 32'h0);

    // R12 writing zero clears channel fields
    csr_wr(3'd4, 32'h0);
    csr_rd(3'd4, v);
    chk(v == 0, "R12 channel cleared", v, 32'h0);

    // R12 start needs enable
    csr_wr(3'd0, 32'h0);
    build_chain(1, 1, 0);
    start(1'b0);
    memhs = 0;
    repeat (30) @(negedge clk);
    csr_rd(3'd4, v);
    chk(memhs == 0 && v[7] == 1'b1, "R12 held while disabled", 32'(memhs), 32'h0);
    csr_wr(3'd0, 32'h1);
    wait_done(ch);
    chk(ch[3:0] == 4'hF, "R12 runs once enabled", ch, 32'hF);

    // R2 soft reset aborts a stalled transfer; R12 busy write ignored
    build_chain(1, 2, 0);
    rx_en = 0;
    start(1'b1);
    repeat (20) @(negedge clk);
    csr_wr(3'd4, 32'h0);
    csr_rd(3'd4, v);
    chk(v[7] == 1'b1 && v[22] == 1'b1, "R12 busy write ignored", v, 32'h0040_0080);
    csr_wr(3'd0, 32'h101);
    csr_rd(3'd4, v);
    chk(v == 0, "R2 soft reset clears channel", v, 32'h0);
    csr_rd(3'd0, v);
    chk(v == 32'h1, "R2 reset bit reads zero", v, 32'h1);
    rx_en = 1; rx_n = 8; rx_i = 0;
    repeat (10) @(negedge clk);
    chk(rx_i == 0, "R2 no word accepted after abort", 32'(rx_i), 32'h0);
    rx_en = 0;
    build_chain(1, 2, 0);
    fill_bufs(1, 2);
    start(1'b0);
    wait_done(ch);
    chk(ch[3:0] == 4'hF && txn == 2, "R2 restart after abort", 32'(txn), 32'h2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule